// File: doc/BRIEF.md
# Segmented Pointer Adder with Segment Carry

The block adds a signed 8-bit displacement to an 8-bit offset, for example an instruction pointer or a stack pointer. When the offset leaves its 256-byte window, the block can pass the wrap into the 8-bit segment that goes with it. Software can then treat the segment and offset together as one 16-bit linear pointer. If the result wraps upward, the segment goes up by one. If the result borrows below zero, the segment goes down by one.

Carry into the segment is possible only for two pairs: the code pair and the stack pair. Each of these pairs has its own enable flag, and separate set and clear commands change that flag while the block runs. Any other target gets a plain 8-bit add, and its segment passes through unchanged. The add path is combinational. The only registered state is the two enable flags.

Top module: `seg_ptr_adder`

## Requirements
- R1: After a synchronous active-high reset, both carry-enable flags are off. With the flags off, a wrapping add on any target leaves the segment output equal to the segment input.
- R2: `off_out` is always the low 8 bits of `off_in + sign_extend(disp_in)`. `disp_in` is a two's-complement value from -128 to +127.
- R3: If the selected pair's flag is on and the sum is 256 or more (upward wrap), `seg_out = seg_in + 1` modulo 256. Example: 0xFF + 0x03 with segment 0x00 gives offset 0x02 and segment 0x01.
- R4: If the selected pair's flag is on and the sum is below zero (borrow), `seg_out = seg_in - 1` modulo 256.
- R5: If the sum stays in the range 0 to 255, `seg_out = seg_in` whatever the flags are. Example: 0x7F + 0x7F with segment 0x00 gives offset 0xFE and segment 0x00.
- R6: `tgt_sel` encoding: 2'b00 selects the code pair, 2'b01 selects the stack pair, and 2'b10 and 2'b11 select other registers. For other registers, `seg_out = seg_in` at all times.
- R7: `cry_set` and `cry_clr` change only the flag chosen by `flag_sel` (0 = code, 1 = stack), on the rising clock edge. If both are high in the same cycle, clear wins. The flag state is visible only through its effect on `seg_out`, starting in the cycle after the edge.
- R8: The segment wraps modulo 256 on its own: 0xFF becomes 0x00 on a carry, and 0x00 becomes 0xFF on a borrow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| off_in | input | 8 | Offset operand |
| disp_in | input | 8 | Signed displacement |
| seg_in | input | 8 | Paired segment value |
| tgt_sel | input | 2 | Target: 0 code, 1 stack, 2/3 other |
| cry_set | input | 1 | Turn on the carry flag chosen by flag_sel |
| cry_clr | input | 1 | Turn off the carry flag chosen by flag_sel |
| flag_sel | input | 1 | Flag choice: 0 code, 1 stack |
| off_out | output | 8 | New offset |
| seg_out | output | 8 | New segment |

## Verification
The assertions assume the inputs are stable, known values in every sampled cycle. They also assume that `seg_out` depends only on the flag value from the previous edge, so a command changes the output one cycle later. The bench changes inputs only on the falling edge and samples the outputs a quarter period later. Each flag command is followed by one full clock edge before any result that depends on it is checked. That way every check sees settled combinational outputs and a flag state that has already been registered.

// File: rtl/seg_adder_pkg.sv
package seg_adder_pkg;

    parameter int OFF_W = 8;
    parameter int SEG_W = 8;
    localparam int SUM_W = OFF_W + 2;

    typedef enum logic [1:0] {
        TGT_CODE  = 2'b00,
        TGT_STACK = 2'b01,
        TGT_GEN_A = 2'b10,
        TGT_GEN_B = 2'b11
    } tgt_e;

    typedef enum logic [1:0] {
        WRAP_NONE = 2'b00,
        WRAP_UP   = 2'b01,
        WRAP_DOWN = 2'b10
    } wrap_e;

    typedef struct packed {
        logic [OFF_W-1:0] off;
        wrap_e            wrap;
    } off_res_t;

    function automatic logic pair_capable(input tgt_e t);
        return (t == TGT_CODE) || (t == TGT_STACK);
    endfunction

endpackage

// File: rtl/seg_carry_flags.sv
module seg_carry_flags
    import seg_adder_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cry_set,
    input  logic cry_clr,
    input  logic flag_sel,
    output logic code_en,
    output logic stack_en
);
    localparam int NFLAG = 2;
    logic [NFLAG-1:0] flg_q;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flg_q[g] <= 1'b0;
            else if (flag_sel == g[0]) begin
                if (cry_clr)      flg_q[g] <= 1'b0;
                else if (cry_set) flg_q[g] <= 1'b1;
            end
        end

        // R7: the flag that flag_sel does not choose keeps its value
        assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
            (flag_sel != g[0]) |=> $stable(flg_q[g]));
        // R7: clear takes priority over set
        assert_clr_wins_R7: assert property (@(posedge clk) disable iff (rst)
            (flag_sel == g[0] && cry_clr) |=> !flg_q[g]);
    end

    assign code_en  = flg_q[0];
    assign stack_en = flg_q[1];
endmodule

// File: rtl/seg_off_add.sv
module seg_off_add
    import seg_adder_pkg::*;
(
    input  logic [OFF_W-1:0] off_in,
    input  logic [OFF_W-1:0] disp_in,
    output off_res_t         res
);
    logic signed [SUM_W-1:0] sum;

    always_comb begin
        sum = $signed({2'b00, off_in}) + $signed({{2{disp_in[OFF_W-1]}}, disp_in});
        res.off = sum[OFF_W-1:0];
        if (sum < 0)
            res.wrap = WRAP_DOWN;
        else if (sum > $signed(SUM_W'((1 << OFF_W) - 1)))
            res.wrap = WRAP_UP;
        else
            res.wrap = WRAP_NONE;
    end

    // R2: a positive displacement can never produce a borrow
    always_comb begin
        if (!disp_in[OFF_W-1])
            assert_pos_no_borrow_R2: assert (res.wrap != WRAP_DOWN);
    end
endmodule

// File: rtl/seg_adjust.sv
module seg_adjust
    import seg_adder_pkg::*;
(
    input  logic [SEG_W-1:0] seg_in,
    input  wrap_e            wrap,
    input  logic             carry_on,
    output logic [SEG_W-1:0] seg_out
);
    always_comb begin
        seg_out = seg_in;
        if (carry_on) begin
            unique case (wrap)
                WRAP_UP:   seg_out = seg_in + SEG_W'(1);
                WRAP_DOWN: seg_out = seg_in - SEG_W'(1);
                default:   seg_out = seg_in;
            endcase
        end
    end
endmodule

// File: rtl/seg_ptr_adder.sv
module seg_ptr_adder
    import seg_adder_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OFF_W-1:0] off_in,
    input  logic [OFF_W-1:0] disp_in,
    input  logic [SEG_W-1:0] seg_in,
    input  logic [1:0]       tgt_sel,
    input  logic             cry_set,
    input  logic             cry_clr,
    input  logic             flag_sel,
    output logic [OFF_W-1:0] off_out,
    output logic [SEG_W-1:0] seg_out
);
    logic     code_en, stack_en, carry_on;
    off_res_t ores;
    tgt_e     tgt;

    assign tgt = tgt_e'(tgt_sel);

    seg_carry_flags u_flags (
        .clk(clk), .rst(rst), .cry_set(cry_set), .cry_clr(cry_clr),
        .flag_sel(flag_sel), .code_en(code_en), .stack_en(stack_en)
    );

    seg_off_add u_add (.off_in(off_in), .disp_in(disp_in), .res(ores));

    always_comb begin
        carry_on = 1'b0;
        if (pair_capable(tgt))
            carry_on = (tgt == TGT_CODE) ? code_en : stack_en;
    end

    seg_adjust u_seg (.seg_in(seg_in), .wrap(ores.wrap), .carry_on(carry_on), .seg_out(seg_out));

    assign off_out = ores.off;

    // R6: targets other than the two pairs pass the segment through
    assert_other_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (tgt_sel[1]) |-> (seg_out == seg_in));
    // R5: when there is no wrap, the segment is unchanged
    assert_no_wrap_pass_R5: assert property (@(posedge clk) disable iff (rst)
        (ores.wrap == WRAP_NONE) |-> (seg_out == seg_in));
    // R1: in the cycle after reset, both flags are off
    assert_reset_off_R1: assert property (@(posedge clk)
        $past(rst) |-> (!code_en && !stack_en));
    // R8: the segment moves by at most one step
    assert_seg_step_R8: assert property (@(posedge clk) disable iff (rst)
        (seg_out == seg_in) || (seg_out == seg_in + SEG_W'(1)) || (seg_out == seg_in - SEG_W'(1)));
endmodule

// File: tb/seg_ptr_adder_tb.sv
module seg_ptr_adder_tb;
    logic clk = 0, rst = 1;
    logic [7:0] off_in = 0, disp_in = 0, seg_in = 0;
    logic [1:0] tgt_sel = 0;
    logic cry_set = 0, cry_clr = 0, flag_sel = 0;
    logic [7:0] off_out, seg_out;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    seg_ptr_adder u_dut (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] o, input logic [7:0] d, input logic [7:0] s, input logic [1:0] t);
        @(negedge clk);
        off_in = o; disp_in = d; seg_in = s; tgt_sel = t;
        #1;
    endtask

    task automatic flag_cmd(input logic sel, input logic st, input logic cl);
        @(negedge clk);
        flag_sel = sel; cry_set = st; cry_clr = cl;
        @(negedge clk);
        cry_set = 0; cry_clr = 0;
    endtask

    task automatic t_reset;
        apply(8'hFF, 8'h03, 8'h00, 2'd0); chk("R1 code", seg_out, 8'h00);
        apply(8'hFF, 8'h03, 8'h10, 2'd1); chk("R1 stack", seg_out, 8'h10);
        chk("R2 offset", off_out, 8'h02);
    endtask

    task automatic t_carry;
        flag_cmd(0, 1, 0);
        apply(8'hFF, 8'h03, 8'h00, 2'd0); chk("R3 seg", seg_out, 8'h01); chk("R3 off", off_out, 8'h02);
        apply(8'h7F, 8'h7F, 8'h00, 2'd0); chk("R5 seg", seg_out, 8'h00); chk("R5 off", off_out, 8'hFE);
        apply(8'hF0, 8'h20, 8'h20, 2'd1); chk("R7 stack untouched", seg_out, 8'h20);
    endtask

    task automatic t_borrow;
        apply(8'h02, 8'hFD, 8'h05, 2'd0); chk("R4 seg", seg_out, 8'h04); chk("R2 neg off", off_out, 8'hFF);
        apply(8'h10, 8'hF0, 8'h05, 2'd0); chk("R5 zero", seg_out, 8'h05); chk("R2 zero", off_out, 8'h00);
        apply(8'h00, 8'h80, 8'h00, 2'd0); chk("R8 borrow wrap", seg_out, 8'hFF); chk("R2 -128", off_out, 8'h80);
        apply(8'hFF, 8'h01, 8'hFF, 2'd0); chk("R8 carry wrap", seg_out, 8'h00);
    endtask

    task automatic t_other;
        apply(8'hFF, 8'h03, 8'h33, 2'd2); chk("R6 sel2", seg_out, 8'h33);
        apply(8'h00, 8'hFF, 8'h44, 2'd3); chk("R6 sel3", seg_out, 8'h44); chk("R6 off", off_out, 8'hFF);
    endtask

    task automatic t_flags;
        flag_cmd(1, 1, 0);
        apply(8'hF0, 8'h20, 8'h20, 2'd1); chk("R7 stack on", seg_out, 8'h21);
        flag_cmd(0, 1, 1);
        apply(8'hFF, 8'h03, 8'h00, 2'd0); chk("R7 clr wins", seg_out, 8'h00);
        apply(8'hF0, 8'h20, 8'h20, 2'd1); chk("R7 stack kept", seg_out, 8'h21);
        flag_cmd(1, 0, 1);
        apply(8'hF0, 8'h20, 8'h20, 2'd1); chk("R7 stack off", seg_out, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset; t_carry; t_borrow; t_other; t_flags;
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                n_run++; n_fail++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule